// File: doc/BRIEF.md
# Page-Granular Bus Memory Mapper

This block decodes every access of an 8-bit CPU with a 16-bit address bus and decides where it goes. The target is either an onboard SRAM or a bidirectional data transceiver that reaches the host mainboard. The address space is cut into sixteen 4 KiB pages, indexed by the top four address bits. A small table holds one routing bit and one write-protect bit per page. An external controller writes that table through a synchronous port while the CPU is held in reset.

Select outputs are pure combinational functions of the address, the read/write line and the registered table, so they settle within the bus cycle that needs them. The 2 KiB I/O window in the upper half of page 14 always goes to the mainboard. An optional swap mode exchanges the two lowest 16 KiB regions. This lets onboard SRAM act as zero page and stack while the mainboard's low memory is tested at its swapped location. A global enable sends everything to the mainboard, so the machine runs on its own memory.

Top module: `pmap_bus_mapper`

## Requirements
- R1: The effective address bits [15:12] select the page. Map bit 1 routes the page to SRAM (`sram_cs_o`=1, `xcvr_en_o`=0). Map bit 0 routes it to the mainboard (`xcvr_en_o`=1, `sram_cs_o`=0).
- R2: `sram_cs_o` and `xcvr_en_o` are never 1 together, for any page, address or access type.
- R3: `xcvr_to_cpu_o` is 1 on reads (`cpu_rw_i`=1) and 0 on writes (`cpu_rw_i`=0), whatever the routing.
- R4: Effective addresses 0xE800–0xEFFF always go to the mainboard, whatever the map bit of page 14. Addresses 0xE000–0xE7FF follow that map bit.
- R5: A write to an SRAM-routed page in 8..15 with its protect bit set asserts neither `sram_cs_o` nor `xcvr_en_o` nor `sram_we_o`. A read of that page asserts `sram_cs_o`.
- R6: Protect bits written for pages 0..7 have no effect. Writes to SRAM-routed low pages assert `sram_we_o`.
- R7: With `swap_en_i`=1 and address bit 15 low, address bit 14 is inverted before the page decode and on `sram_addr_o`. With bit 15 high, or with swap off, `sram_addr_o` equals `cpu_addr_i`.
- R8: After reset, every page routes to the mainboard and is unprotected. A configuration write (`cfg_we_i`=1 at a rising clock edge) sets the map and protect bits of page `cfg_page_i` from the next cycle on and leaves the other pages unchanged.
- R9: With `map_en_i`=0, every access goes to the mainboard, whatever the table holds.
- R10: `sram_we_o` is 1 only when `sram_cs_o` is 1 and the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_page_i | input | 4 | Page index to write |
| cfg_map_i | input | 1 | Routing bit: 1 = SRAM, 0 = mainboard |
| cfg_prot_i | input | 1 | Write-protect bit |
| map_en_i | input | 1 | 0 forces all pages to the mainboard |
| swap_en_i | input | 1 | Low-memory swap control |
| cpu_addr_i | input | 16 | CPU address |
| cpu_rw_i | input | 1 | 1 = read, 0 = write |
| sram_addr_o | output | 16 | SRAM address after swap |
| sram_cs_o | output | 1 | SRAM select |
| sram_we_o | output | 1 | SRAM write enable |
| xcvr_en_o | output | 1 | Mainboard transceiver enable |
| xcvr_to_cpu_o | output | 1 | Transceiver direction, 1 = toward CPU |

## Verification
The hardest cases to reach are those where several overrides meet on one access. One is a protected write in page 14 on each side of the I/O hole. Another is a swapped low address whose page routing differs from the page the CPU actually named. The bench reaches them by loading table patterns through the configuration port with routing and protection set independently per page. It then sweeps every page with reads and writes, at both halves of each page, with swap off and on. Each result is compared against a model computed from the requirements.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int ADDR_W    = 16;
  localparam int PAGE_BITS = 4;
  localparam int NUM_PAGES = 1 << PAGE_BITS;
  localparam int HOLE_PAGE = 14;
  localparam int HOLE_BIT  = 11;
  localparam int SWAP_BIT  = ADDR_W - 2;
  typedef logic [PAGE_BITS-1:0] page_t;
  typedef logic [ADDR_W-1:0]    addr_t;
endpackage

// File: rtl/pmap_cfg_regs.sv
module pmap_cfg_regs
  import pmap_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  page_t                cfg_page_i,
  input  logic                 cfg_map_i,
  input  logic                 cfg_prot_i,
  output logic [NUM_PAGES-1:0] map_q_o,
  output logic [NUM_PAGES-1:0] prot_q_o
);
  localparam int PROT_LO = NUM_PAGES / 2;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    logic hit;
    assign hit = cfg_we_i && (cfg_page_i == page_t'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  map_q_o[g] <= 1'b0;
      else if (hit) map_q_o[g] <= cfg_map_i;
    end

    if (g >= PROT_LO) begin : g_prot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  prot_q_o[g] <= 1'b0;
        else if (hit) prot_q_o[g] <= cfg_prot_i;
      end
    end else begin : g_noprot
      assign prot_q_o[g] = 1'b0;  // low half is plain RAM
    end
  end

  // R8: a write lands in the addressed page
  a_r8_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> map_q_o[$past(cfg_page_i)] == $past(cfg_map_i));
  // R6: low-half protect state never set
  a_r6_low_unprot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_q_o[PROT_LO-1:0] == '0);
endmodule

// File: rtl/pmap_addr_xlate.sv
module pmap_addr_xlate
  import pmap_pkg::*;
(
  input  addr_t cpu_addr_i,
  input  logic  swap_en_i,
  output addr_t eff_addr_o,
  output page_t page_o,
  output logic  hole_o,
  output logic  upper_o
);
  logic swap_act;
  assign swap_act   = swap_en_i && !cpu_addr_i[ADDR_W-1];
  assign eff_addr_o = swap_act ? (cpu_addr_i ^ (addr_t'(1) << SWAP_BIT)) : cpu_addr_i;
  assign page_o     = eff_addr_o[ADDR_W-1 -: PAGE_BITS];
  assign upper_o    = page_o[PAGE_BITS-1];
  assign hole_o     = (page_o == page_t'(HOLE_PAGE)) && eff_addr_o[HOLE_BIT];
endmodule

// File: rtl/pmap_route.sv
module pmap_route (
  input  logic map_en_i,
  input  logic map_bit_i,
  input  logic prot_bit_i,
  input  logic upper_i,
  input  logic hole_i,
  input  logic rw_i,
  output logic sram_cs_o,
  output logic sram_we_o,
  output logic xcvr_en_o,
  output logic xcvr_to_cpu_o
);
  logic onboard, blocked;
  assign onboard       = map_en_i && map_bit_i && !hole_i;
  // protected write: drop the access on both sides
  assign blocked       = onboard && !rw_i && upper_i && prot_bit_i;
  assign sram_cs_o     = onboard && !blocked;
  assign sram_we_o     = sram_cs_o && !rw_i;
  assign xcvr_en_o     = !onboard;
  assign xcvr_to_cpu_o = rw_i;
endmodule

// File: rtl/pmap_bus_mapper.sv
module pmap_bus_mapper
  import pmap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [3:0]  cfg_page_i,
  input  logic        cfg_map_i,
  input  logic        cfg_prot_i,
  input  logic        map_en_i,
  input  logic        swap_en_i,
  input  logic [15:0] cpu_addr_i,
  input  logic        cpu_rw_i,
  output logic [15:0] sram_addr_o,
  output logic        sram_cs_o,
  output logic        sram_we_o,
  output logic        xcvr_en_o,
  output logic        xcvr_to_cpu_o
);
  logic [NUM_PAGES-1:0] map_q, prot_q;
  addr_t eff_addr;
  page_t page;
  logic  hole, upper;

  pmap_cfg_regs u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_page_i, .cfg_map_i, .cfg_prot_i,
    .map_q_o(map_q), .prot_q_o(prot_q)
  );

  pmap_addr_xlate u_xlate (
    .cpu_addr_i, .swap_en_i,
    .eff_addr_o(eff_addr), .page_o(page), .hole_o(hole), .upper_o(upper)
  );

  pmap_route u_route (
    .map_en_i, .map_bit_i(map_q[page]), .prot_bit_i(prot_q[page]),
    .upper_i(upper), .hole_i(hole), .rw_i(cpu_rw_i),
    .sram_cs_o, .sram_we_o, .xcvr_en_o, .xcvr_to_cpu_o
  );

  assign sram_addr_o = eff_addr;

  a_r2_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_cs_o && xcvr_en_o));
  a_r4_io_hole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_addr_o[15:11] == 5'b11101) |-> (xcvr_en_o && !sram_cs_o));
  a_r9_global_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_en_i |-> (xcvr_en_o && !sram_cs_o));
  a_r10_we_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> (sram_cs_o && !cpu_rw_i));
  a_r7_upper_noswap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15] |-> (sram_addr_o == cpu_addr_i));
  a_r3_dir_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rw_i && xcvr_en_o) |-> xcvr_to_cpu_o);
endmodule

// File: tb/pmap_bus_mapper_tb_top.sv
`timescale 1ns/1ps
module pmap_bus_mapper_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_map = 0, cfg_prot = 0, map_en = 1, swap_en = 0, cpu_rw = 1;
  logic [3:0] cfg_page = 0;
  logic [15:0] cpu_addr = 0, sram_addr;
  logic sram_cs, sram_we, xcvr_en, xcvr_dir;
  logic [15:0] sh_map = 0, sh_prot = 0;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pmap_bus_mapper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_page_i(cfg_page),
    .cfg_map_i(cfg_map), .cfg_prot_i(cfg_prot), .map_en_i(map_en), .swap_en_i(swap_en),
    .cpu_addr_i(cpu_addr), .cpu_rw_i(cpu_rw), .sram_addr_o(sram_addr),
    .sram_cs_o(sram_cs), .sram_we_o(sram_we), .xcvr_en_o(xcvr_en), .xcvr_to_cpu_o(xcvr_dir)
  );

  task automatic cfg_wr(input int pg, input logic m, input logic p);
    @(negedge clk);
    cfg_we = 1; cfg_page = pg[3:0]; cfg_map = m; cfg_prot = p;
    @(negedge clk);
    cfg_we = 0;
    sh_map[pg] = m;
    if (pg >= 8) sh_prot[pg] = p;  // R6: low protect has no storage effect
  endtask

  task automatic load(input logic [15:0] m, input logic [15:0] p);
    for (int i = 0; i < 16; i++) cfg_wr(i, m[i], p[i]);
  endtask

  // model from requirements: {addr, cs, we, en, dir}
  function automatic logic [19:0] model(input logic [15:0] a, input logic rw);
    logic [15:0] e; logic [3:0] pg; logic on, blk, cs;
    e   = (swap_en && !a[15]) ? {a[15], ~a[14], a[13:0]} : a;
    pg  = e[15:12];
    on  = map_en && sh_map[pg] && !(pg == 4'd14 && e[11]);
    blk = on && !rw && pg[3] && sh_prot[pg];
    cs  = on && !blk;
    return {e, cs, cs && !rw, !on, rw};
  endfunction

  task automatic chk(input logic [15:0] a, input logic rw, input string tag);
    logic [19:0] exp_v, act;
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw;
    #2;
    exp_v = model(a, rw);
    act = {sram_addr, sram_cs, sram_we, xcvr_en, xcvr_dir};
    n_tests++;
    if (act !== exp_v || (sram_cs && xcvr_en)) begin
      n_fail++;
      $display("FAIL %s addr=%h rw=%b actual={addr %h cs%b we%b en%b dir%b} expected={addr %h cs%b we%b en%b dir%b}",
               tag, a, rw, act[19:4], act[3], act[2], act[1], act[0],
               exp_v[19:4], exp_v[3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  task automatic sweep(input string tag);
    for (int pg = 0; pg < 16; pg++)
      for (int r = 0; r < 2; r++) begin
        chk({pg[3:0], 12'h123}, r[0], tag);
        chk({pg[3:0], 12'hA5C}, r[0], tag);
      end
  endtask

  task automatic t_reset;   // R8 defaults, R3 direction
    sweep("R8_reset");
  endtask

  task automatic t_map;     // R1 R2 R3 R10
    load(16'hA5C3, 16'h0000);
    sweep("R1_map");
    load(16'h5A3C, 16'h0000);
    sweep("R2_excl");
    chk(16'h1000, 1'b0, "R10_we");
    chk(16'h1000, 1'b1, "R3_dir");
  endtask

  task automatic t_hole;    // R4
    load(16'hFFFF, 16'h0000);
    chk(16'hE000, 1'b1, "R4_below");
    chk(16'hE7FF, 1'b0, "R4_below");
    chk(16'hE800, 1'b1, "R4_hole");
    chk(16'hEFFF, 1'b0, "R4_hole");
    cfg_wr(14, 1'b0, 1'b0);
    chk(16'hE400, 1'b1, "R4_mapoff");
  endtask

  task automatic t_prot;    // R5 R6
    load(16'hFFFF, 16'hFFFF);
    chk(16'h9000, 1'b0, "R5_wr_blocked");
    chk(16'h9000, 1'b1, "R5_rd_ok");
    chk(16'hE100, 1'b0, "R5_e_page");
    chk(16'hE900, 1'b0, "R5_hole_wr");
    chk(16'h2000, 1'b0, "R6_low_wr");
    chk(16'h7FFF, 1'b0, "R6_low_wr");
    cfg_wr(11, 1'b1, 1'b0);
    chk(16'hB000, 1'b0, "R5_unprot");
    sweep("R5_sweep");
  endtask

  task automatic t_swap;    // R7
    load(16'h0010, 16'h0000);
    swap_en = 1;
    chk(16'h0010, 1'b0, "R7_low_to_sram");
    chk(16'h4010, 1'b1, "R7_mid_to_main");
    chk(16'h2345, 1'b1, "R7_addr");
    chk(16'hC000, 1'b1, "R7_upper");
    sweep("R7_sweep");
    swap_en = 0;
    chk(16'h0010, 1'b1, "R7_off");
  endtask

  task automatic t_global;  // R9
    load(16'hFFFF, 16'h0000);
    map_en = 0;
    sweep("R9_global");
    map_en = 1;
    chk(16'h3000, 1'b1, "R9_restore");
  endtask

  task automatic t_update;  // R8
    load(16'h0000, 16'h0000);
    cfg_wr(5, 1'b1, 1'b0);
    chk(16'h5000, 1'b1, "R8_update");
    chk(16'h6000, 1'b1, "R8_other");
    cfg_wr(5, 1'b0, 1'b0);
    chk(16'h5000, 1'b1, "R8_rewrite");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_hole();
    t_prot();
    t_swap();
    t_global();
    t_update();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule